// File: doc/BRIEF.md
# Two-Byte-Instruction 8-bit Processor Core

This block is a small 8-bit processor with a single memory that holds both code and data. It has two working registers (A and B), a sum register that captures A+B, an instruction register, an operand register and a program counter. Every register output, the memory read data and the operand byte feed one shared source selector, which drives the internal data bus. A second selector over the same set of sources forms the memory address. Addition is the only arithmetic. Subtraction is done by adding a negated value, and the only decision the core can make is a jump taken when the sum register holds zero.

Each instruction is two bytes: an opcode byte followed by an operand byte. The operand byte is fetched even when the instruction does not use it. The opcode is split into a 2-bit kind in bits [7:6], a 3-bit source field in bits [5:3] and a 3-bit target field in bits [2:0]. A six-stage ring executes each instruction in this order: address the opcode, capture it, address the operand, capture it, address the execute access, commit.

A preload port writes the internal 256-byte RAM directly, so a program can be placed in memory while the core is held in reset. Every memory write made by the core is also visible at the ports.

Top module: `duo_byte_cpu`

## Requirements
- R1: A synchronous active-high `rst` clears PC, A, B, the sum register, the instruction register and the operand register to zero and restarts the ring at the opcode-address stage. It holds them there for as long as it is asserted.
- R2: Every instruction takes exactly six clock cycles. `retire_o` is high for one cycle out of six, and the PC advances by one after each of the two fetch captures.
- R3: Kind 00 (bits [7:6]) copies the source chosen by bits [5:3] into the target chosen by bits [2:0]. Source codes: 000=A, 001=B, 010=sum, 011=operand byte, 100=PC, 101=memory. Target codes: 000=A, 001=B, 010=sum, 100=PC.
- R4: Any write to the sum register stores A+B modulo 256, whatever source is selected. `zero_o` is high exactly when the sum register holds 0.
- R5: Kind 01 writes memory at the address given by source code bits [5:3], with data taken from the source chosen by bits [2:0]. During the commit cycle of that instruction, and only then, it shows `wr_en_o`=1 together with that address and data.
- R6: Kind 10 reads memory at the address given by source code bits [5:3] and writes the byte read into the target chosen by bits [2:0]. A PC target makes this an indirect jump.
- R7: Kind 11 loads the PC with the operand byte when the sum register is zero, and otherwise continues with the next instruction. Opcode bits [5:0] have no effect on this kind.
- R8: Source codes 110 and 111 read as zero. Target codes 011, 101, 110 and 111 change no register.
- R9: The PC used as a source gives the address of the instruction that follows the one executing.
- R10: In kind 00, the memory source (101) reads the byte at the address held in the operand byte.
- R11: A preload write (`ld_we`=1) stores `ld_data` at `ld_addr` on the clock edge, and a later instruction can read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write strobe into the RAM |
| ld_addr | input | 8 | Preload address |
| ld_data | input | 8 | Preload data |
| pc_o | output | 8 | Program counter |
| a_o | output | 8 | Register A |
| b_o | output | 8 | Register B |
| acc_o | output | 8 | Sum register |
| zero_o | output | 1 | Sum register equals zero |
| retire_o | output | 1 | High during the commit cycle of each instruction |
| wr_en_o | output | 1 | Core memory write in this cycle |
| wr_addr_o | output | 8 | Address of the core memory write |
| wr_data_o | output | 8 | Data of the core memory write |

## Verification
The bench runs a program that drives the sum through an 8-bit wrap to exactly zero. A core that kept a ninth bit, or tested the live adder instead of the stored sum, would take the wrong branch or skip the taken one. A jump opcode with all of its low six bits set checks that the kind-11 decode ignores them, and a core that decoded those bits would write a register or a memory location it should not touch. Further cases target the reserved source and target codes, a PC read used as data, which must show the post-fetch address rather than the opcode's own address, and a sum write issued from a memory-read instruction, which must still store A+B. The bench also runs an indirect jump through a preloaded table entry and register-addressed stores and loads, where a misrouted address selector writes or reads the wrong byte.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int WORD = 8;

    // instruction kind, opcode bits [7:6]
    typedef enum logic [1:0] {
        K_MOVE   = 2'b00,
        K_STORE  = 2'b01,
        K_LOAD   = 2'b10,
        K_BRANCH = 2'b11
    } kind_e;

    // shared source / target code space
    typedef enum logic [2:0] {
        P_A    = 3'd0,
        P_B    = 3'd1,
        P_SUM  = 3'd2,
        P_ARG  = 3'd3,
        P_PC   = 3'd4,
        P_MEM  = 3'd5,
        P_RSV6 = 3'd6,
        P_RSV7 = 3'd7
    } port_e;

    // one-hot ring positions
    localparam int N_STAGE      = 6;
    localparam int ST_OP_ADDR   = 0;
    localparam int ST_OP_CAP    = 1;
    localparam int ST_ARG_ADDR  = 2;
    localparam int ST_ARG_CAP   = 3;
    localparam int ST_EX_ADDR   = 4;
    localparam int ST_EX_COMMIT = 5;

    typedef struct packed {
        port_e addr_sel;
        port_e bus_sel;
        logic  ir_we;
        logic  arg_we;
        logic  pc_inc;
        logic  pc_we;
        logic  a_we;
        logic  b_we;
        logic  sum_we;
        logic  mem_we;
    } ctl_t;

    // turn a target code into a register write strobe
    function automatic ctl_t with_target(ctl_t c, logic [2:0] tgt);
        ctl_t r = c;
        case (tgt)
            3'd0:    r.a_we   = 1'b1;
            3'd1:    r.b_we   = 1'b1;
            3'd2:    r.sum_we = 1'b1;
            3'd4:    r.pc_we  = 1'b1;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpu_seq.sv
module cpu_seq
    import cpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [N_STAGE-1:0] stage
);

    always_ff @(posedge clk) begin
        if (rst) stage <= N_STAGE'(1);
        else     stage <= {stage[N_STAGE-2:0], stage[N_STAGE-1]};
    end

endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
#(
    parameter int DW = WORD
) (
    input  logic [N_STAGE-1:0] stage,
    input  logic [DW-1:0]      ir,
    input  logic               sum_zero,
    output ctl_t               ctl
);

    kind_e kind;
    port_e src_f;
    port_e tgt_f;

    assign kind  = kind_e'(ir[DW-1 -: 2]);
    assign src_f = port_e'(ir[5:3]);
    assign tgt_f = port_e'(ir[2:0]);

    always_comb begin
        ctl          = '0;
        ctl.addr_sel = P_PC;
        ctl.bus_sel  = P_MEM;
        if (stage[ST_OP_CAP]) begin
            ctl.ir_we  = 1'b1;
            ctl.pc_inc = 1'b1;
        end
        if (stage[ST_ARG_CAP]) begin
            ctl.arg_we = 1'b1;
            ctl.pc_inc = 1'b1;
        end
        if (stage[ST_EX_ADDR]) begin
            ctl.addr_sel = (kind == K_STORE || kind == K_LOAD) ? src_f : P_ARG;
        end
        if (stage[ST_EX_COMMIT]) begin
            case (kind)
                K_MOVE: begin
                    ctl.bus_sel = src_f;
                    ctl = with_target(ctl, ir[2:0]);
                end
                K_STORE: begin
                    ctl.addr_sel = src_f;
                    ctl.bus_sel  = tgt_f;
                    ctl.mem_we   = 1'b1;
                end
                K_LOAD: begin
                    ctl.addr_sel = src_f;
                    ctl.bus_sel  = P_MEM;
                    ctl = with_target(ctl, ir[2:0]);
                end
                default: begin
                    ctl.bus_sel = P_ARG;
                    ctl.pc_we   = sum_zero;
                end
            endcase
        end
    end

endmodule

// File: rtl/cpu_ram.sv
module cpu_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        rdata <= cells[addr];
    end

endmodule

// File: rtl/duo_byte_cpu.sv
module duo_byte_cpu
    import cpu_pkg::*;
#(
    parameter int DW = WORD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [DW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] b_o,
    output logic [DW-1:0] acc_o,
    output logic          zero_o,
    output logic          retire_o,
    output logic          wr_en_o,
    output logic [DW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    localparam int AW = DW;   // address space equals the word range

    logic [N_STAGE-1:0] stage;
    ctl_t               ctl;
    logic [DW-1:0]      pc_q, a_q, b_q, sum_q, ir_q, arg_q, mem_q;
    logic [DW-1:0]      bus, addr_bus;
    logic               sum_zero, core_we, ram_we;
    logic [AW-1:0]      ram_addr;
    logic [DW-1:0]      ram_wd;

    function automatic logic [DW-1:0] route(port_e sel);
        case (sel)
            P_A:     return a_q;
            P_B:     return b_q;
            P_SUM:   return sum_q;
            P_ARG:   return arg_q;
            P_PC:    return pc_q;
            P_MEM:   return mem_q;
            default: return '0;
        endcase
    endfunction

    cpu_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .stage (stage)
    );

    cpu_ctrl #(.DW(DW)) u_ctrl (
        .stage    (stage),
        .ir       (ir_q),
        .sum_zero (sum_zero),
        .ctl      (ctl)
    );

    assign sum_zero = (sum_q == '0);
    assign bus      = route(ctl.bus_sel);
    assign addr_bus = route(ctl.addr_sel);
    assign core_we  = ctl.mem_we & ~rst;
    assign ram_we   = ld_we | core_we;
    assign ram_addr = ld_we ? ld_addr : addr_bus;
    assign ram_wd   = ld_we ? ld_data : bus;

    cpu_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wd),
        .rdata (mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            sum_q <= '0;
            ir_q  <= '0;
            arg_q <= '0;
        end else begin
            if (ctl.ir_we)  ir_q  <= bus;
            if (ctl.arg_we) arg_q <= bus;
            if (ctl.a_we)   a_q   <= bus;
            if (ctl.b_we)   b_q   <= bus;
            if (ctl.sum_we) sum_q <= a_q + b_q;
            if (ctl.pc_we)       pc_q <= bus;
            else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
        end
    end

    assign pc_o      = pc_q;
    assign a_o       = a_q;
    assign b_o       = b_q;
    assign acc_o     = sum_q;
    assign zero_o    = sum_zero;
    assign retire_o  = stage[ST_EX_COMMIT];
    assign wr_en_o   = core_we & ~ld_we;
    assign wr_addr_o = addr_bus;
    assign wr_data_o = bus;

    // R1: one cycle after reset drops, the architectural state is clear
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !rst) |-> (pc_q == '0 && a_q == '0 && b_q == '0 && sum_q == '0));

    // R2: the opcode capture advances the PC by exactly one
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        stage[ST_OP_CAP] |=> (pc_q == DW'($past(pc_q) + 1'b1)));

    // R4: a sum write stores the wrapped total of A and B
    assert_sum_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.sum_we |=> (sum_q == DW'($past(a_q) + $past(b_q))));

    // R5: core memory writes only occur in the commit stage of a store
    assert_store_window_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (retire_o && ir_q[DW-1 -: 2] == K_STORE));

    // R7: an untaken conditional jump leaves the PC alone
    assert_branch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (retire_o && ir_q[DW-1 -: 2] == K_BRANCH && sum_q != '0) |=> $stable(pc_q));

endmodule

// File: tb/duo_byte_cpu_tb.sv
`timescale 1ns/1ps
module duo_byte_cpu_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] pc_o, a_o, b_o, acc_o, wr_addr_o, wr_data_o;
    logic       zero_o, retire_o, wr_en_o;

    always #2.5 clk = ~clk;

    duo_byte_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .pc_o      (pc_o),
        .a_o       (a_o),
        .b_o       (b_o),
        .acc_o     (acc_o),
        .zero_o    (zero_o),
        .retire_o  (retire_o),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    typedef struct {
        logic [7:0] a, b, acc, pc;
        bit         wr;
        logic [7:0] wa, wd;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   retired = 0;
    int   cyc = 0;
    bit   run = 0;
    localparam int N_STEPS = 22;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic want(logic [7:0] a, logic [7:0] b, logic [7:0] acc, logic [7:0] pc,
                        bit wr, logic [7:0] wa, logic [7:0] wd, string req);
        exp_t e;
        e.a = a; e.b = b; e.acc = acc; e.pc = pc;
        e.wr = wr; e.wa = wa; e.wd = wd; e.req = req;
        sb.push_back(e);
    endtask

    task automatic poke(logic [7:0] addr, logic [7:0] data);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = addr; ld_data = data;
    endtask

    task automatic put(logic [7:0] addr, logic [7:0] op, logic [7:0] arg);
        poke(addr, op);
        poke(addr + 8'd1, arg);
    endtask

    // monitor: pops one expected item per retired instruction
    initial begin
        exp_t e;
        int   last;
        last = -1;
        forever begin
            @(negedge clk);
            if (run && !rst && retire_o && sb.size() != 0) begin
                e = sb.pop_front();
                if (last >= 0) chk("R2", "retire spacing", 8'(cyc - last), 8'd6);
                last = cyc;
                chk(e.req, "wr_en", {7'b0, wr_en_o}, {7'b0, e.wr});
                if (e.wr) begin
                    chk(e.req, "wr_addr", wr_addr_o, e.wa);
                    chk(e.req, "wr_data", wr_data_o, e.wd);
                end
                @(negedge clk);
                chk(e.req, "A", a_o, e.a);
                chk(e.req, "B", b_o, e.b);
                chk(e.req, "sum", acc_o, e.acc);
                chk(e.req, "PC", pc_o, e.pc);
                chk("R4", "zero flag", {7'b0, zero_o}, {7'b0, (e.acc == 8'h00)});
                retired++;
            end
        end
    end

    initial begin
        bit done;
        // program (loaded through the preload port, R11)
        put(8'h00, 8'h18, 8'h95);   // A <- 0x95
        put(8'h02, 8'h19, 8'hFB);   // B <- 0xFB
        put(8'h04, 8'h02, 8'h00);   // sum
        put(8'h06, 8'h10, 8'h00);   // A <- sum
        put(8'h08, 8'h58, 8'h80);   // [0x80] <- A
        put(8'h0A, 8'h99, 8'h80);   // B <- [0x80]
        put(8'h0C, 8'h02, 8'h00);   // sum (wraps)
        put(8'h0E, 8'h41, 8'h00);   // [A] <- B
        put(8'h10, 8'hFF, 8'h40);   // jump-if-zero, extra bits set, not taken
        put(8'h12, 8'h18, 8'h70);   // A <- 0x70
        put(8'h14, 8'h02, 8'h00);   // sum -> 0
        put(8'h16, 8'hC0, 8'h30);   // taken to 0x30
        put(8'h30, 8'h21, 8'h00);   // B <- PC
        put(8'h32, 8'h9A, 8'h80);   // sum target from memory read
        put(8'h34, 8'h30, 8'h00);   // A <- reserved source 110
        put(8'h36, 8'h1B, 8'h77);   // reserved target 011
        put(8'h38, 8'h28, 8'h80);   // A <- mem[operand]
        put(8'h3A, 8'h1C, 8'h60);   // PC <- 0x60
        put(8'h60, 8'h9C, 8'hA0);   // PC <- [0xA0]
        put(8'h70, 8'h5A, 8'h81);   // [0x81] <- sum
        put(8'h72, 8'h81, 8'h00);   // B <- [A]
        put(8'h74, 8'hC0, 8'h00);   // not taken
        poke(8'hA0, 8'h70);         // jump table entry
        @(negedge clk);
        ld_we = 1'b0;

        // R1: held in reset
        chk("R1", "reset PC", pc_o, 8'h00);
        chk("R1", "reset A", a_o, 8'h00);
        chk("R1", "reset B", b_o, 8'h00);
        chk("R1", "reset sum", acc_o, 8'h00);
        chk("R1", "reset retire", {7'b0, retire_o}, 8'h00);
        chk("R1", "reset wr_en", {7'b0, wr_en_o}, 8'h00);

        want(8'h95, 8'h00, 8'h00, 8'h02, 0, 0, 0, "R3 operand to A");
        want(8'h95, 8'hFB, 8'h00, 8'h04, 0, 0, 0, "R3 operand to B");
        want(8'h95, 8'hFB, 8'h90, 8'h06, 0, 0, 0, "R4 add");
        want(8'h90, 8'hFB, 8'h90, 8'h08, 0, 0, 0, "R3 sum to A");
        want(8'h90, 8'hFB, 8'h90, 8'h0A, 1, 8'h80, 8'h90, "R5 store at operand");
        want(8'h90, 8'h90, 8'h90, 8'h0C, 0, 0, 0, "R6 load to B");
        want(8'h90, 8'h90, 8'h20, 8'h0E, 0, 0, 0, "R4 wrap");
        want(8'h90, 8'h90, 8'h20, 8'h10, 1, 8'h90, 8'h90, "R5 store at A");
        want(8'h90, 8'h90, 8'h20, 8'h12, 0, 0, 0, "R7 untaken, bits ignored");
        want(8'h70, 8'h90, 8'h20, 8'h14, 0, 0, 0, "R3 operand to A");
        want(8'h70, 8'h90, 8'h00, 8'h16, 0, 0, 0, "R4 wrap to zero");
        want(8'h70, 8'h90, 8'h00, 8'h30, 0, 0, 0, "R7 taken");
        want(8'h70, 8'h32, 8'h00, 8'h32, 0, 0, 0, "R9 PC source");
        want(8'h70, 8'h32, 8'hA2, 8'h34, 0, 0, 0, "R4 sum ignores source");
        want(8'h00, 8'h32, 8'hA2, 8'h36, 0, 0, 0, "R8 reserved source");
        want(8'h00, 8'h32, 8'hA2, 8'h38, 0, 0, 0, "R8 reserved target");
        want(8'h90, 8'h32, 8'hA2, 8'h3A, 0, 0, 0, "R10 memory source");
        want(8'h90, 8'h32, 8'hA2, 8'h60, 0, 0, 0, "R3 PC target");
        want(8'h90, 8'h32, 8'hA2, 8'h70, 0, 0, 0, "R6 R11 indirect jump");
        want(8'h90, 8'h32, 8'hA2, 8'h72, 1, 8'h81, 8'hA2, "R5 store sum");
        want(8'h90, 8'h90, 8'hA2, 8'h74, 0, 0, 0, "R6 load via A");
        want(8'h90, 8'h90, 8'hA2, 8'h76, 0, 0, 0, "R7 untaken");

        @(negedge clk);
        rst = 1'b0;
        run = 1'b1;

        done = 0;
        for (int i = 0; i < 2000 && !done; i++) begin
            @(negedge clk);
            if (retired == N_STEPS) done = 1;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d retired expected %0d", retired, N_STEPS);
        end

        // R1: reset during a run clears state
        run = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "rerun PC", pc_o, 8'h00);
        chk("R1", "rerun A", a_o, 8'h00);
        chk("R1", "rerun B", b_o, 8'h00);
        chk("R1", "rerun sum", acc_o, 8'h00);
        chk("R1", "rerun retire", {7'b0, retire_o}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule